// File: doc/BRIEF.md
# Flash command decoder model

A synthesizable model of a byte-wide parallel flash device, seen from the device side. It watches single-cycle write strobes on a byte bus and recognises the unlock-and-command sequences. From those it performs a byte program, which can only clear bits. It performs sector, block and whole-array erase, which set bytes to 0xFF. It also switches into and out of an identification mode. The storage is a small register file, and its size, sector size and block size are parameters.

Each operation starts a busy period with a fixed cycle count per operation type. While busy, the device answers every read with a status byte instead of array data. Status bit 6 flips on each such read. Status bit 7 is the inverse of bit 7 of the byte being written, and is 0 during an erase. Software sees the operation as finished once two reads agree or bit 7 matches. Writes that arrive while busy are dropped. The model replaces real timing with short counters, so a host-side programming engine can be exercised cycle-accurately.

Top module: `flash_cmd_model`

## Requirements
- R1: A command byte is accepted only after two back-to-back writes: 0xAA at address 0x5555, then 0x55 at address 0x2AAA. Any other write in that window, or any unknown command byte, returns the decoder to idle with no effect on the array or the mode.
- R2: Writing 0xA0 at 0x5555 as the command arms a program. The next write ANDs its data into the byte at array offset (address mod DEPTH), so a bit can go from 1 to 0 but never back to 1.
- R3: Writing 0x80 at 0x5555 as the command arms erase, which then needs a second unlock pair. After that, 0x30 at any address erases the SECT_BYTES-sized sector holding that offset, 0x50 erases the BLOCK_BYTES-sized block, and 0x10 at 0x5555 erases the whole array. Every affected byte becomes 0xFF. A final write matching none of these returns the decoder to idle with nothing erased.
- R4: Writing 0x90 at 0x5555 as the command enters identification mode. There, a read with address bit 0 = 0 returns MFR_ID and a read with address bit 0 = 1 returns DEV_ID. Writing 0xF0 at 0x5555 as the command returns reads to array data.
- R5: The write that starts an operation makes busy high for exactly T_PROG, T_SECT, T_BLOCK or T_CHIP cycles. A read presented in any of those cycles returns status, and a read in the cycle after returns the updated array data.
- R6: A status byte has bits 5:0 = 0. Its bit 6 equals an internal toggle that is 0 after reset and inverts after every status read, so consecutive status reads differ in bit 6.
- R7: Status bit 7 is the complement of bit 7 of the programmed data during a program, and 0 during any erase.
- R8: A write presented while busy is high, including in the last busy cycle, is ignored: it neither advances the command sequence nor changes the array or the mode.
- R9: After reset every array byte reads 0xFF, busy is low, the read data output is 0x00, and the device is in array-read mode.
- R10: The read data output updates in the cycle after a read strobe and holds its value while no read is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_re | input | 1 | Read strobe, one cycle per bus read |
| bus_addr | input | AW | Byte address of the bus cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, status byte or ID code, registered |
| busy | output | 1 | High while a program or erase is running |

## Verification
The block's end of busy period and a new bus cycle can fall in the same clock cycle. In the final busy cycle a read must still return status, and a write must still be dropped. The bench provokes this for reads by polling exactly T cycles after each random program or erase. It checks every status byte against a bench-side toggle and polarity model, and checks that the very next read gives the new data. For writes, it places an unlock write in the last busy cycle and follows it with the rest of a program sequence. It then judges the outcome by reading back that the target byte was left unchanged.

// File: rtl/flash_cmd_model.sv
module flash_cmd_model #(
  parameter int AW = 16,
  parameter int DEPTH = 256,
  parameter int SECT_BYTES = 16,
  parameter int BLOCK_BYTES = 64,
  parameter int T_PROG = 4,
  parameter int T_SECT = 6,
  parameter int T_BLOCK = 9,
  parameter int T_CHIP = 12,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'hB5,
  parameter logic [AW-1:0] UNLOCK_A1 = 'h5555,
  parameter logic [AW-1:0] UNLOCK_A2 = 'h2AAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          busy
);
  localparam int IW = $clog2(DEPTH);
  localparam int SW = $clog2(SECT_BYTES);
  localparam int BW = $clog2(BLOCK_BYTES);
  localparam int TM1 = (T_PROG > T_SECT) ? T_PROG : T_SECT;
  localparam int TM2 = (T_BLOCK > T_CHIP) ? T_BLOCK : T_CHIP;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int CW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_CMD, S_PROG, S_E1, S_E2, S_E3} seq_t;

  seq_t          st;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt;
  logic          id_mode, tog, poll;

  wire [IW-1:0] idx   = bus_addr[IW-1:0];
  wire          wr_ok = bus_we && !busy;
  wire          at_a1 = bus_addr == UNLOCK_A1;
  wire          at_a2 = bus_addr == UNLOCK_A2;
  wire          key1  = at_a1 && bus_wdata == 8'hAA;
  wire          key2  = at_a2 && bus_wdata == 8'h55;

  wire do_prog = wr_ok && st == S_PROG;
  wire do_sect = wr_ok && st == S_E3 && bus_wdata == 8'h30;
  wire do_blk  = wr_ok && st == S_E3 && bus_wdata == 8'h50;
  wire do_chip = wr_ok && st == S_E3 && bus_wdata == 8'h10 && at_a1;

  assign busy = cnt != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      id_mode <= 1'b0;
    end else if (wr_ok) begin
      st <= S_IDLE;
      case (st)
        S_IDLE: if (key1) st <= S_U1;
        S_U1:   if (key2) st <= S_CMD;
        S_CMD: if (at_a1) begin
          case (bus_wdata)
            8'hA0: st <= S_PROG;
            8'h80: st <= S_E1;
            8'h90: id_mode <= 1'b1;
            8'hF0: id_mode <= 1'b0;
            default: ;
          endcase
        end
        S_E1: if (key1) st <= S_E2;
        S_E2: if (key2) st <= S_E3;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      poll <= 1'b0;
    end else if (do_prog) begin
      cnt <= CW'(T_PROG);
      poll <= ~bus_wdata[7];
    end else if (do_sect || do_blk || do_chip) begin
      cnt <= do_chip ? CW'(T_CHIP) : (do_blk ? CW'(T_BLOCK) : CW'(T_SECT));
      poll <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) mem[i] <= 8'hFF;
      else if (do_chip) mem[i] <= 8'hFF;
      else if (do_sect && (IW'(i) >> SW) == (idx >> SW)) mem[i] <= 8'hFF;
      else if (do_blk && (IW'(i) >> BW) == (idx >> BW)) mem[i] <= 8'hFF;
      else if (do_prog && IW'(i) == idx) mem[i] <= mem[i] & bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 8'h00;
      tog <= 1'b0;
    end else if (bus_re) begin
      if (busy) begin
        bus_rdata <= {poll, tog, 6'b0};
        tog <= ~tog;
      end else if (id_mode) begin
        bus_rdata <= bus_addr[0] ? DEV_ID : MFR_ID;
      end else begin
        bus_rdata <= mem[idx];
      end
    end
  end

  AST_WRITE_WHILE_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_we |=> $stable(st) && $stable(id_mode)); // R8
  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |=> (mem[$past(idx)] & ~$past(bus_wdata)) == 8'h00); // R2
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && busy |=> bus_rdata[5:0] == 6'b0); // R6
  AST_TOGGLE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && busy && $past(bus_re && busy) |=> bus_rdata[6] != $past(bus_rdata[6])); // R6
  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cnt == $past(cnt) - CW'(1)); // R5
  AST_BUSY_STARTS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we)); // R5
  AST_ID_READ_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode && !busy && bus_re |=> bus_rdata == MFR_ID || bus_rdata == DEV_ID); // R4
endmodule

// File: tb/tb_flash_cmd_model.sv
module tb_flash_cmd_model;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 256;
  localparam int SECT = 16;
  localparam int BLK = 64;
  localparam int TP = 4, TS = 6, TB = 9, TC = 12;
  localparam logic [7:0] MFR = 8'hBF, DEV = 8'hB5;
  localparam logic [15:0] A1 = 16'h5555, A2 = 16'h2AAA;

  logic clk = 0, rst_n = 0, bus_we = 0, bus_re = 0;
  logic [15:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic busy;
  int vectors = 0, miscompares = 0;
  logic [7:0] exp_mem [DEPTH];
  logic exp_tog;

  flash_cmd_model dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] stat(input logic p);
    return {p, exp_tog, 6'b0};
  endfunction

  function automatic bit same_unit(input int a, input int b, input int sz);
    return (a % DEPTH) / sz == (b % DEPTH) / sz;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic unlock();
    wr(A1, 8'hAA); wr(A2, 8'h55);
  endtask

  task automatic poll(input int t, input logic p, input logic [15:0] a, input bit final_rd);
    logic [7:0] d;
    for (int j = 0; j < t; j++) begin
      chk("R5 busy high in window", {7'b0, busy}, 8'h01);
      rd(a, d);
      chk("R6 R7 status byte", d, stat(p));
      exp_tog = ~exp_tog;
    end
    if (final_rd) begin
      rd(a, d);
      chk("R5 data after busy", d, exp_mem[a % DEPTH]);
    end
  endtask

  task automatic do_program(input logic [15:0] a, input logic [7:0] d);
    unlock(); wr(A1, 8'hA0); wr(a, d);
    exp_mem[a % DEPTH] &= d;
    poll(TP, ~d[7], a, 1);
  endtask

  task automatic do_erase(input int kind, input logic [15:0] a);
    int t;
    unlock(); wr(A1, 8'h80); unlock();
    case (kind)
      0: begin wr(a, 8'h30); t = TS; end
      1: begin wr(a, 8'h50); t = TB; end
      default: begin wr(A1, 8'h10); t = TC; end
    endcase
    for (int i = 0; i < DEPTH; i++)
      if (kind == 2 || (kind == 0 && same_unit(i, a, SECT)) || (kind == 1 && same_unit(i, a, BLK)))
        exp_mem[i] = 8'hFF;
    poll(t, 1'b0, a, 1);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp_mem[a % DEPTH]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [15:0] a;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = 8'hFF;
    exp_tog = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    chk("R9 busy low after reset", {7'b0, busy}, 8'h00);
    chk("R9 rdata zero after reset", bus_rdata, 8'h00);
    rd_chk("R9 array erased after reset", 16'h0033);

    do_program(16'h0010, 8'hF0);
    do_program(16'h0010, 8'h3C);
    chk("R2 program only clears", exp_mem[16], 8'h30);
    rd_chk("R2 AND result", 16'h0010);
    do_program(16'h0110, 8'hFF);
    rd_chk("R2 address alias and all-ones program", 16'h0010);

    repeat (2) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 8'h30);

    unlock(); wr(A1, 8'h90);
    rd(16'h0000, d); chk("R4 manufacturer code", d, MFR);
    rd(16'h0001, d); chk("R4 device code", d, DEV);
    rd(16'h0100, d); chk("R4 code by bit 0", d, MFR);
    unlock(); wr(A1, 8'hF0);
    rd_chk("R4 exit to array reads", 16'h0010);

    wr(A1, 8'hAA); wr(16'h1234, 8'h12); wr(A2, 8'h55); wr(A1, 8'hA0); wr(16'h0020, 8'h00);
    chk("R1 broken unlock no busy", {7'b0, busy}, 8'h00);
    rd_chk("R1 broken unlock no program", 16'h0020);
    unlock(); wr(A1, 8'h77); wr(A1, 8'hA0); wr(16'h0021, 8'h00);
    rd_chk("R1 unknown command returns idle", 16'h0021);
    unlock(); wr(A1, 8'h80); unlock(); wr(16'h4444, 8'h10);
    chk("R3 chip erase needs 0x5555", {7'b0, busy}, 8'h00);

    unlock(); wr(A1, 8'hA0); wr(16'h0040, 8'h5A);
    exp_mem[8'h40] &= 8'h5A;
    poll(TP - 1, 1'b1, 16'h0040, 0);
    wr(A1, 8'hAA);
    wr(A2, 8'h55); wr(A1, 8'hA0); wr(16'h0040, 8'h00);
    rd_chk("R8 write in last busy cycle ignored", 16'h0040);

    do_program(16'h0037, 8'h00);
    do_erase(0, 16'h0031);
    rd_chk("R3 sector erased", 16'h0037);
    rd_chk("R3 outside sector kept", 16'h0040);
    do_program(16'h0080, 8'h11);
    do_program(16'h00BF, 8'h22);
    do_program(16'h00C0, 8'h33);
    do_erase(1, 16'h0090);
    rd_chk("R3 block low edge erased", 16'h0080);
    rd_chk("R3 block high edge erased", 16'h00BF);
    rd_chk("R3 next block kept", 16'h00C0);
    do_erase(2, 16'h0000);
    rd_chk("R3 chip erase", 16'h00C0);

    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 20;
      a = 16'($urandom);
      if (op < 12) do_program(a, 8'($urandom));
      else if (op < 15) do_erase(0, a);
      else if (op < 17) do_erase(1, a);
      else if (op == 17) do_erase(2, a);
      else if (op == 18) begin
        wr(A1, 8'hAA); wr(A2, 8'h54); wr(A2, 8'h55); wr(A1, 8'hA0); wr(a, 8'h00);
        chk("R1 random broken sequence no busy", {7'b0, busy}, 8'h00);
      end
      rd_chk("R2 R3 random array check", 16'($urandom));
      rd_chk("R2 R3 touched byte check", a);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule